// File: doc/BRIEF.md
# Data-Value Watchpoint Unit

This block is a bank of debug watchpoint comparators that sits beside the memory-access stage of a processor pipeline. Every entry can watch either the address of a load or store or the data value moving with it. This lets a handler be entered at chosen points in the instruction stream when a particular value passes through memory, and not only when a particular location is touched. Addresses presented to the unit are physical, so a match is the same whatever virtual address the accessing code used.

Each entry holds a compare value, a bit mask and a control field. The control field has an enable, an operand select (address or data), and separate qualifiers for loads and for stores. Bits cleared in the mask are don't-care. When any enabled entry matches a valid access, the unit sends a registered trap request toward a handler-entry controller. The request carries the index of the lowest-numbered matching entry. A simple register write port loads the configuration.

Top module: `wpt_unit`

## Requirements
- R1: After a synchronous reset, trap_req and trap_idx are 0 and every entry is disabled, so no access raises a trap until software enables an entry.
- R2: An enabled entry in address mode (control bit 1 = 0) matches when ((acc_addr XOR compare) AND mask) is zero. The access data is not used in address mode.
- R3: An enabled entry in data mode (control bit 1 = 1) matches when ((acc_data XOR compare) AND mask) is zero. The access address is not used in data mode.
- R4: An entry matches a load (acc_store = 0) only when its load-check bit (control bit 2) is set. It matches a store (acc_store = 1) only when its store-check bit (control bit 3) is set.
- R5: No entry matches when its enable bit (control bit 0) is clear, and nothing matches when acc_valid is low.
- R6: When several entries match the same access, trap_idx reports the lowest-numbered one. trap_idx is 0 in any cycle where trap_req is low.
- R7: trap_req is high for exactly the one clock cycle that follows a matching access. Back-to-back matching accesses give back-to-back pulses.
- R8: A write with cfg_we high loads cfg_wdata into the field picked by cfg_sel (0 = compare, 1 = mask, 2 = control in bits 3:0; 3 is ignored) of entry cfg_idx. The write takes effect for accesses from the next cycle on and leaves every other field and entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IW | Entry number to write |
| cfg_sel | input | 2 | Field select: compare, mask, control |
| cfg_wdata | input | VW | Write data |
| acc_valid | input | 1 | A memory access is present this cycle |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | AW | Physical address of the access |
| acc_data | input | DW | Data loaded or stored |
| trap_req | output | 1 | One-cycle trap request |
| trap_idx | output | IW | Lowest matching entry, 0 when idle |

## Verification
An access presented in one cycle shows its result on trap_req and trap_idx after the following rising edge, one register stage later. A configuration write reaches the comparators one edge after it is presented. Every bench step therefore drives inputs on the falling edge and samples the outputs 1 ns after the next rising edge. The expected result is computed from the configuration as it stood before that step's write, which also checks that a write does not affect an access in the same cycle. Idle steps after matching accesses confirm that the request lasts only one cycle.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  // Control field layout: bit0 enable, bit1 data mode, bit2 loads, bit3 stores
  typedef struct packed {
    logic chk_st;
    logic chk_ld;
    logic on_data;
    logic enable;
  } wpt_ctl_t;

  localparam logic [1:0] SEL_CMP = 2'd0;
  localparam logic [1:0] SEL_MSK = 2'd1;
  localparam logic [1:0] SEL_CTL = 2'd2;
endpackage

// File: rtl/wpt_cfg_bank.sv
module wpt_cfg_bank
  import wpt_pkg::*;
#(
  parameter int N  = 4,
  parameter int VW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic                   we_i,
  input  logic [IW-1:0]          idx_i,
  input  logic [1:0]             sel_i,
  input  logic [VW-1:0]          wdata_i,
  output logic [N-1:0][VW-1:0]   cmp_o,
  output logic [N-1:0][VW-1:0]   msk_o,
  output wpt_ctl_t [N-1:0]       ctl_o
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic hit_w;
    assign hit_w = we_i && (idx_i == IW'(g));
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        cmp_o[g] <= '0;
        msk_o[g] <= '0;
        ctl_o[g] <= '0;
      end else if (hit_w) begin
        if (sel_i == SEL_CMP) cmp_o[g] <= wdata_i;
        if (sel_i == SEL_MSK) msk_o[g] <= wdata_i;
        if (sel_i == SEL_CTL) ctl_o[g] <= wpt_ctl_t'(wdata_i[3:0]);
      end
    end
  end

  // R8: configuration only moves on a write strobe
  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(we_i) |-> ($stable(ctl_o) && $stable(msk_o) && $stable(cmp_o)))
    else $error("config changed without write");
endmodule

// File: rtl/wpt_cmp.sv
module wpt_cmp
  import wpt_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int VW = 32
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          acc_valid_i,
  input  logic          acc_store_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [DW-1:0] acc_data_i,
  input  logic [VW-1:0] cmp_i,
  input  logic [VW-1:0] msk_i,
  input  wpt_ctl_t      ctl_i,
  output logic          hit_o
);
  logic [VW-1:0] opnd_w;
  logic          kind_ok_w;
  logic          eq_w;

  assign opnd_w    = ctl_i.on_data ? VW'(acc_data_i) : VW'(acc_addr_i);
  assign kind_ok_w = acc_store_i ? ctl_i.chk_st : ctl_i.chk_ld;
  assign eq_w      = (((opnd_w ^ cmp_i) & msk_i) == '0);
  assign hit_o     = acc_valid_i && ctl_i.enable && kind_ok_w && eq_w;

  // R5: a disabled entry stays silent
  p_off_silent_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !ctl_i.enable |-> !hit_o) else $error("disabled entry hit");
  // R4: access kind must be qualified by the entry
  p_kind_qual_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_o |-> (acc_store_i ? ctl_i.chk_st : ctl_i.chk_ld)) else $error("kind");
endmodule

// File: rtl/wpt_prio.sv
module wpt_prio #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [N-1:0]  hit_i,
  output logic          trap_req_o,
  output logic [IW-1:0] trap_idx_o
);
  logic [IW-1:0] low_w;

  always_comb begin
    low_w = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) low_w = IW'(i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      trap_req_o <= 1'b0;
      trap_idx_o <= '0;
    end else begin
      trap_req_o <= |hit_i;
      trap_idx_o <= (|hit_i) ? low_w : '0;
    end
  end

  // R6: reported entry did hit, and no lower entry hit
  p_lowest_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    trap_req_o |-> ((($past(hit_i) >> trap_idx_o) & N'(1)) != '0) &&
                   (($past(hit_i) & ((N'(1) << trap_idx_o) - N'(1))) == '0))
    else $error("priority");
endmodule

// File: rtl/wpt_unit.sv
module wpt_unit
  import wpt_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int VW = (AW > DW) ? AW : DW,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [1:0]    cfg_sel,
  input  logic [VW-1:0] cfg_wdata,
  input  logic          acc_valid,
  input  logic          acc_store,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_data,
  output logic          trap_req,
  output logic [IW-1:0] trap_idx
);
  logic [N-1:0][VW-1:0] cmp_w;
  logic [N-1:0][VW-1:0] msk_w;
  wpt_ctl_t [N-1:0]     ctl_w;
  logic [N-1:0]         hit_w;

  wpt_cfg_bank #(.N(N), .VW(VW)) u_cfg (
    .clk_i(clk), .rst_i(rst), .we_i(cfg_we), .idx_i(cfg_idx),
    .sel_i(cfg_sel), .wdata_i(cfg_wdata),
    .cmp_o(cmp_w), .msk_o(msk_w), .ctl_o(ctl_w)
  );

  for (genvar g = 0; g < N; g++) begin : g_cmp
    wpt_cmp #(.AW(AW), .DW(DW), .VW(VW)) u_cmp (
      .clk_i(clk), .rst_i(rst),
      .acc_valid_i(acc_valid), .acc_store_i(acc_store),
      .acc_addr_i(acc_addr), .acc_data_i(acc_data),
      .cmp_i(cmp_w[g]), .msk_i(msk_w[g]), .ctl_i(ctl_w[g]),
      .hit_o(hit_w[g])
    );
  end

  wpt_prio #(.N(N)) u_prio (
    .clk_i(clk), .rst_i(rst), .hit_i(hit_w),
    .trap_req_o(trap_req), .trap_idx_o(trap_idx)
  );

  // R7: a request always follows a valid access
  p_req_after_acc_r7: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $past(acc_valid)) else $error("request without access");
  // R6: index is zero while idle
  p_idle_idx_r6: assert property (@(posedge clk) disable iff (rst)
    !trap_req |-> (trap_idx == '0)) else $error("idle index");
endmodule

// File: tb/wpt_unit_tb.sv
module wpt_unit_tb_top;
  localparam int N = 4, AW = 32, DW = 32, VW = 32, IW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0; logic [IW-1:0] cfg_idx = 0; logic [1:0] cfg_sel = 0;
  logic [VW-1:0] cfg_wdata = 0;
  logic acc_valid = 0, acc_store = 0;
  logic [AW-1:0] acc_addr = 0; logic [DW-1:0] acc_data = 0;
  logic trap_req; logic [IW-1:0] trap_idx;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [VW-1:0] sh_cmp [N];
  logic [VW-1:0] sh_msk [N];
  logic [3:0]    sh_ctl [N];

  always #2 clk = ~clk;

  wpt_unit #(.N(N), .AW(AW), .DW(DW)) dut_i (.*);

  function automatic bit ent_hit(int i, bit st, logic [AW-1:0] a, logic [DW-1:0] d);
    logic [VW-1:0] op;
    op = sh_ctl[i][1] ? d : a;
    if (!sh_ctl[i][0]) return 0;
    if (st ? !sh_ctl[i][3] : !sh_ctl[i][2]) return 0;
    return ((op ^ sh_cmp[i]) & sh_msk[i]) == 0;
  endfunction

  task automatic check(string tag, logic er, logic [IW-1:0] ei);
    n_chk++;
    if (trap_req !== er || trap_idx !== ei) begin
      n_bad++;
      $display("FAIL %s: trap_req=%0b trap_idx=%0d expected %0b/%0d",
               tag, trap_req, trap_idx, er, ei);
    end
  endtask

  // one cycle: optional config write plus optional access, then check result
  task automatic step(string tag, bit we, int idx, int sel, logic [VW-1:0] wd,
                      bit av, bit st, logic [AW-1:0] a, logic [DW-1:0] d);
    logic er; logic [IW-1:0] ei;
    @(negedge clk);
    cfg_we = we; cfg_idx = IW'(idx); cfg_sel = 2'(sel); cfg_wdata = wd;
    acc_valid = av; acc_store = st; acc_addr = a; acc_data = d;
    er = 0; ei = 0;
    if (av) for (int i = N - 1; i >= 0; i--) if (ent_hit(i, st, a, d)) begin er = 1; ei = IW'(i); end
    if (we) begin
      if (sel == 0) sh_cmp[idx] = wd;
      if (sel == 1) sh_msk[idx] = wd;
      if (sel == 2) sh_ctl[idx] = wd[3:0];
    end
    @(posedge clk); #1;
    check(tag, er, ei);
  endtask

  task automatic wr(int idx, int sel, logic [VW-1:0] wd);
    step("R8", 1, idx, sel, wd, 0, 0, 0, 0);
  endtask

  task automatic acc(string tag, bit st, logic [AW-1:0] a, logic [DW-1:0] d);
    step(tag, 0, 0, 0, 0, 1, st, a, d);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    for (int i = 0; i < N; i++) begin sh_cmp[i] = 0; sh_msk[i] = 0; sh_ctl[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    #1 check("R1 reset", 0, 0);
    // R1: all entries off after reset (zero mask would otherwise match)
    acc("R1 disabled", 0, 32'h0, 32'h0);
    acc("R1 disabled", 1, 32'hFFFF_FFFF, 32'h1234);

    // R2: entry0 address mode, low byte don't-care, loads+stores
    wr(0, 0, 32'h0000_1000); wr(0, 1, 32'hFFFF_FF00); wr(0, 2, 32'hD);
    acc("R2 match", 0, 32'h0000_1010, 32'h0);
    acc("R2 miss", 0, 32'h0000_2010, 32'h0000_1000);
    acc("R2 masked bits", 1, 32'h0000_10FF, 32'h5);

    // R3: entry1 data mode, low half compared, loads+stores
    wr(1, 0, 32'h0000_CAFE); wr(1, 1, 32'h0000_FFFF); wr(1, 2, 32'hF);
    acc("R3 match", 0, 32'h0000_5000, 32'h1234_CAFE);
    acc("R3 miss", 1, 32'h0000_5000, 32'h0000_CAFF);
    acc("R3 addr ignored", 0, 32'h0000_CAFE, 32'h0);

    // R4: entry2 exact address, stores only
    wr(2, 0, 32'h0000_3000); wr(2, 1, 32'hFFFF_FFFF); wr(2, 2, 32'h9);
    acc("R4 load ignored", 0, 32'h0000_3000, 32'h0);
    acc("R4 store", 1, 32'h0000_3000, 32'h0);
    wr(2, 2, 32'h5);
    acc("R4 load", 0, 32'h0000_3000, 32'h0);
    acc("R4 store ignored", 1, 32'h0000_3000, 32'h0);

    // R6: entry0 and entry1 both match
    acc("R6 lowest", 0, 32'h0000_1020, 32'h0000_CAFE);
    wr(0, 2, 32'hC); // enable cleared
    acc("R5 R6 disabled skip", 0, 32'h0000_1020, 32'h0000_CAFE);
    // R5: valid low with matching values
    step("R5 no valid", 0, 0, 0, 0, 0, 0, 32'h0000_1020, 32'h0000_CAFE);

    // R8: entry3 write and access in the same cycle, then next cycle
    wr(3, 1, 32'h0);
    step("R8 same cycle", 1, 3, 2, 32'hF, 1, 0, 32'h0000_9000, 32'h0);
    acc("R8 next cycle", 0, 32'h0000_9000, 32'h0);
    step("R8 sel3 ignored", 1, 3, 3, 32'h0, 1, 1, 32'h0000_9000, 32'h0);

    // R7: back-to-back pulses then idle
    acc("R7 first", 0, 32'h0000_1111, 32'h0000_CAFE);
    acc("R7 second", 1, 32'h0000_1111, 32'h0000_CAFE);
    idle("R7 drop");
    idle("R7 stay low");

    // R2/R3 sweep over a small value space
    wr(0, 0, 32'h10); wr(0, 1, 32'hF0); wr(0, 2, 32'hD);
    wr(1, 0, 32'h05); wr(1, 1, 32'h0F); wr(1, 2, 32'h7);
    wr(2, 0, 32'h01); wr(2, 1, 32'h01); wr(2, 2, 32'h9);
    wr(3, 0, 32'h80); wr(3, 1, 32'h80); wr(3, 2, 32'hF);
    lf = 32'hACE1_2345;
    for (int k = 0; k < 1500; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step("R2/R3/R4/R6 sweep", 0, 0, 0, 0, lf[17] | lf[18], lf[16],
           {24'h0, lf[7:0]}, {24'h0, lf[15:8]});
    end
    idle("R7 end");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule